// File: doc/BRIEF.md
# LED Blink Channel with Auto-Stop

This block drives one LED output with a slow, programmable blink. A power-of-two prescaler turns the system clock into a step tick. A step counter walks through a programmable number of steps per blink period. The output is high for a programmable number of leading steps in each period and low for the rest.

Software controls the channel through four word registers. A control register holds the rate selector, an enable, an auto-stop enable and an interrupt mask. The other three hold the period length, the high time and a blink-count limit. With auto-stop on, the channel runs the requested number of periods, then disables itself and can raise a one-cycle interrupt. Reads are combinational and writes take effect at the clock edge. The reset is asynchronous, active low and released synchronously inside the block.

Top module: `led_blink_chan`

## Requirements
- R1: After reset every register reads 0, and `led_out` and `irq` are low.
- R2: Register index 0 is control (7 bits), 1 is period (PER_W bits, default 12), 2 is high time (PER_W bits) and 3 is the blink-count limit (STOP_W bits, default 16). A write keeps only the bits of the register's width, and reads return that value zero-extended. Running the channel never changes the stored limit.
- R3: Control bits [3:0] form rate selector n. Each step lasts 2^(PRE_W-n) clocks (PRE_W default 14). Any value above PRE_W-1 behaves as PRE_W-1.
- R4: With period P and high time D, the output is high during the first D steps of every P-step period. D=0 gives a constant low output, D>=P gives a constant high output, and P=0 behaves as a one-step period.
- R5: Control bit 4 is the enable. While it is 0, `led_out` is low and the step logic holds.
- R6: A write that changes the enable from 0 to 1 starts step 0 in the next cycle with a full-length first step, and reloads the blink count from the limit register.
- R7: Control bit 5 enables auto-stop. After N complete periods (a limit of 0 acts as 1), the enable bit clears and `led_out` is low from the cycle after the last period ends.
- R8: When auto-stop fires, `irq` is high for exactly that one following cycle, unless control bit 6 (mask) was set in the cycle auto-stop fired.
- R9: If a control write lands in the same cycle that auto-stop fires, the written selector, auto-stop and mask bits are kept, the enable reads 0, and the interrupt follows the mask value held before the write.
- R10: With auto-stop off, the channel blinks without end and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for the write |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | DATA_W (16) | Read data, combinational |
| led_out | output | 1 | Blink waveform |
| irq | output | 1 | One-cycle auto-stop interrupt |

## Verification
Auto-stop clearing the enable and a software write to the control register are the two functions that can fall in the same cycle. The bench computes from the step length, period and limit the exact edge at which the final period ends, and it times a control write to land on that edge. It then judges the result at the ports: the control readback must show the written selector and mask with the enable at 0, `led_out` must be low, and `irq` must pulse according to the mask value held before the write.

// File: rtl/ledb_pkg.sv
package ledb_pkg;

  // register indices on the 2-bit address
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PER   = 2'd1,
    REG_HIGH  = 2'd2,
    REG_LIMIT = 2'd3
  } ledb_reg_e;

  // control register layout
  localparam int CTRL_W     = 7;
  localparam int SEL_W      = 4;
  localparam int BIT_EN     = 4;
  localparam int BIT_AUTO   = 5;
  localparam int BIT_MASK   = 6;

endpackage

// File: rtl/ledb_prescale.sv
module ledb_prescale
  import ledb_pkg::*;
#(
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int MAX_SEL = PRE_W - 1;

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_eff;
  logic [PRE_W-1:0] win;

  always_comb begin
    if (int'(sel) > MAX_SEL) sel_eff = SEL_W'(MAX_SEL);
    else                     sel_eff = sel;
    win  = {PRE_W{1'b1}} >> sel_eff;
    tick = run && ((cnt_q & win) == win);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0);

endmodule

// File: rtl/ledb_wave.sv
module ledb_wave #(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              tick,
  input  logic              auto_en,
  input  logic [PER_W-1:0]  period,
  input  logic [PER_W-1:0]  high_time,
  input  logic [STOP_W-1:0] limit,
  output logic              wave,
  output logic              stop_pulse
);

  logic [PER_W-1:0]  step_q, step_d;
  logic [STOP_W-1:0] left_q, left_d;
  logic [PER_W:0]    step_nx;
  logic              last_step;
  logic              per_end;

  always_comb begin
    step_nx   = {1'b0, step_q} + {{PER_W{1'b0}}, 1'b1};
    last_step = step_nx >= {1'b0, period};
    per_end   = tick && last_step;
    stop_pulse = per_end && auto_en && (left_q <= STOP_W'(1));
    wave      = step_q < high_time;
  end

  always_comb begin
    step_d = step_q;
    left_d = left_q;
    if (start) begin
      step_d = '0;
      left_d = limit;
    end else if (tick) begin
      step_d = last_step ? '0 : step_nx[PER_W-1:0];
      if (per_end && auto_en && (left_q != '0))
        left_d = left_q - STOP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      left_q <= '0;
    end else begin
      step_q <= step_d;
      left_q <= left_d;
    end
  end

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(step_q) && $stable(left_q));

  p_start_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (step_q == '0) && (left_q == $past(limit)));

endmodule

// File: rtl/ledb_regs.sv
module ledb_regs
  import ledb_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int STOP_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              stop_pulse,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic [PER_W-1:0]  period,
  output logic [PER_W-1:0]  high_time,
  output logic [STOP_W-1:0] limit,
  output logic              start
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic [PER_W-1:0]  hi_q, hi_d;
  logic [STOP_W-1:0] lim_q, lim_d;
  logic              wr_ctrl;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    start   = wr_ctrl && wr_data[BIT_EN] && !ctrl_q[BIT_EN];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    hi_d   = hi_q;
    lim_d  = lim_q;
    if (wr_en) begin
      case (ledb_reg_e'(wr_addr))
        REG_CTRL:  ctrl_d = wr_data[CTRL_W-1:0];
        REG_PER:   per_d  = wr_data[PER_W-1:0];
        REG_HIGH:  hi_d   = wr_data[PER_W-1:0];
        REG_LIMIT: lim_d  = wr_data[STOP_W-1:0];
        default:   ;
      endcase
    end
    // auto-stop overrides only the enable bit of a colliding write
    if (stop_pulse) ctrl_d[BIT_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      hi_q   <= '0;
      lim_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      hi_q   <= hi_d;
      lim_q  <= lim_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (ledb_reg_e'(rd_addr))
      REG_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      REG_PER:   rd_data[PER_W-1:0]  = per_q;
      REG_HIGH:  rd_data[PER_W-1:0]  = hi_q;
      REG_LIMIT: rd_data[STOP_W-1:0] = lim_q;
      default:   rd_data = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign period    = per_q;
  assign high_time = hi_q;
  assign limit     = lim_q;

  p_stop_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !ctrl_q[BIT_EN]);

  p_collide_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && wr_ctrl) |=> ctrl_q[BIT_MASK] == $past(wr_data[BIT_MASK]));

endmodule

// File: rtl/led_blink_chan.sv
module led_blink_chan
  import ledb_pkg::*;
#(
  parameter int PRE_W  = 14,
  parameter int PER_W  = 12,
  parameter int STOP_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              led_out,
  output logic              irq
);

  logic              rst_meta, rst_sync;
  logic [CTRL_W-1:0] ctrl;
  logic [PER_W-1:0]  period, high_time;
  logic [STOP_W-1:0] limit;
  logic              start, tick, wave, stop_pulse;
  logic              irq_q, irq_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ledb_regs #(.PER_W(PER_W), .STOP_W(STOP_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stop_pulse(stop_pulse),
    .rd_data(rd_data), .ctrl(ctrl), .period(period), .high_time(high_time),
    .limit(limit), .start(start)
  );

  ledb_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_sync), .run(ctrl[BIT_EN]), .start(start),
    .sel(ctrl[SEL_W-1:0]), .tick(tick)
  );

  ledb_wave #(.PER_W(PER_W), .STOP_W(STOP_W)) wave_i (
    .clk(clk), .rst_n(rst_sync), .run(ctrl[BIT_EN]), .start(start),
    .tick(tick), .auto_en(ctrl[BIT_AUTO]), .period(period),
    .high_time(high_time), .limit(limit), .wave(wave),
    .stop_pulse(stop_pulse)
  );

  always_comb irq_d = stop_pulse && !ctrl[BIT_MASK];

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) irq_q <= 1'b0;
    else           irq_q <= irq_d;
  end

  assign led_out = ctrl[BIT_EN] && wave;
  assign irq     = irq_q;

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    irq_q |=> !irq_q);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    irq_q |-> $past(stop_pulse) && !$past(ctrl[BIT_MASK]));

endmodule

// File: tb/led_blink_chan_tb_top.sv
module led_blink_chan_tb_top;

  localparam int PRE_W  = 4;
  localparam int PER_W  = 4;
  localparam int STOP_W = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              led_out, irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  led_blink_chan #(.PRE_W(PRE_W), .PER_W(PER_W), .STOP_W(STOP_W),
                   .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .led_out(led_out), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive at a falling edge, commit at the next rising edge, return one
  // falling edge later (cycle 0 of the new state)
  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 2'(idx);
    wr_data = DATA_W'(val);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input int exp);
    rd_addr = 2'(idx);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  function automatic int step_len(input int n);
    int e;
    e = (n > PRE_W - 1) ? PRE_W - 1 : n;
    return 1 << (PRE_W - e);
  endfunction

  function automatic int exp_led(input int k, input int len, input int p,
                                 input int d);
    int pe;
    pe = (p == 0) ? 1 : p;
    return (((k / len) % pe) < d) ? 1 : 0;
  endfunction

  initial begin
    int pv[4] = '{0, 1, 4, 7};
    int dv[4] = '{0, 1, 4, 9};
    int lv[3] = '{0, 1, 3};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 led", int'(led_out), 0);
    check("R1 irq", int'(irq), 0);
    for (int i = 0; i < 4; i++) rd_chk("R1 reg", i, 0);

    // R2: widths of each register
    wr(0, 16'hFFAF); rd_chk("R2 ctrl", 0, 16'h2F);
    wr(0, 0);
    wr(1, 16'hFFFF); rd_chk("R2 period", 1, 16'h000F);
    wr(2, 16'hFFFF); rd_chk("R2 high", 2, 16'h000F);
    wr(3, 16'hFFFF); rd_chk("R2 limit", 3, 16'h000F);
    check("R2 led idle", int'(led_out), 0);

    // R3 R4 R6 R10: sweep rate, period and high time, auto-stop off
    for (int n = 0; n < 6; n++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int di = 0; di < 4; di++) begin
          int len, pe, span;
          len = step_len(n);
          pe  = (pv[pi] == 0) ? 1 : pv[pi];
          span = 2 * pe * len + 2;
          wr(1, pv[pi]);
          wr(2, dv[di]);
          wr(0, n | 16);
          for (int k = 0; k < span; k++) begin
            check("R4 wave", int'(led_out), exp_led(k, len, pv[pi], dv[di]));
            check("R10 irq", int'(irq), 0);
            @(negedge clk);
          end
          wr(0, n);
          check("R5 off", int'(led_out), 0);
          @(negedge clk);
          check("R5 off hold", int'(led_out), 0);
        end
      end
    end

    // R7 R8: auto-stop with several limits, mask on and off
    for (int li = 0; li < 3; li++) begin
      for (int m = 0; m < 2; m++) begin
        int len, t, nn;
        len = step_len(2);
        nn  = (lv[li] == 0) ? 1 : lv[li];
        t   = nn * 3 * len;
        wr(1, 3);
        wr(2, 1);
        wr(3, lv[li]);
        wr(0, 2 | 16 | 32 | (m << 6));
        for (int k = 0; k < t + 4; k++) begin
          check("R7 wave", int'(led_out), (k < t) ? exp_led(k, len, 3, 1) : 0);
          check("R8 irq", int'(irq), (k == t && m == 0) ? 1 : 0);
          @(negedge clk);
        end
        rd_chk("R7 en cleared", 0, 2 | 32 | (m << 6));
        rd_chk("R2 limit kept", 3, lv[li]);
        wr(0, 0);
      end
    end

    // R9: control write on the auto-stop edge
    begin
      int len, t;
      len = step_len(3);
      t   = 2 * len;
      wr(1, 2);
      wr(2, 1);
      wr(3, 1);
      wr(0, 3 | 16 | 32);
      for (int k = 0; k < t - 1; k++) begin
        check("R9 run", int'(led_out), exp_led(k, len, 2, 1));
        @(negedge clk);
      end
      wr_en   = 1'b1;
      wr_addr = 2'd0;
      wr_data = DATA_W'(1 | 16 | 64);
      @(negedge clk);
      wr_en = 1'b0;
      check("R9 irq old mask", int'(irq), 1);
      check("R9 led", int'(led_out), 0);
      rd_chk("R9 ctrl", 0, 1 | 64);
      @(negedge clk);
      check("R9 irq single", int'(irq), 0);
    end

    // R6: re-enable after stop restarts from step 0 with the limit reloaded
    begin
      int len, t;
      len = step_len(3);
      t   = 2 * len;
      wr(0, 3 | 16 | 32);
      for (int k = 0; k < t + 2; k++) begin
        check("R6 restart", int'(led_out), (k < t) ? exp_led(k, len, 2, 1) : 0);
        check("R6 irq", int'(irq), (k == t) ? 1 : 0);
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule